// File: doc/BRIEF.md
# Serial Slave Register Access Engine

This block is a serial slave port that lets a host read and write two address windows. The first window is a 32-byte RAM at locations 00 to 1F. The second is a clock and control bank at locations 20 to 3F. A transaction opens when chip enable rises. The first byte is a command byte, and any number of data bytes follow it. After each data byte the engine moves on to the next location inside the same window, so a single transaction can sweep a whole bank.

The serial inputs are synchronized into the system clock domain, and all serial edges are found there. The host may idle the serial clock either low or high. The engine reads the idle level at the moment chip enable rises and derives both edges from it. It samples input data on the edge that returns the clock to its idle level. It changes output data on the edge that leaves the idle level.

On the parallel side the engine drives an address, a one-cycle write strobe with data, and a one-cycle read strobe. Registers that clear when read use the read strobe. Read data returns on a combinational input. Reads of clock-bank locations that hold nothing readable return zero. The serial data output has its own enable, which models a three-state pin.

Top module: `spi_reg_access`

## Requirements
- R1: While reset is held and just after it, `miso_oe`, `reg_we` and `reg_re` are all 0.
- R2: The first byte after chip enable rises is the command byte, shifted most significant bit first. Bit 7 set means write and clear means read. Bit 5 set selects the clock bank (location 20+n) and clear selects RAM. Bits 4..0 give n.
- R3: The `sck_i` level sampled when `ce_i` rises is the idle level. `mosi_i` is sampled on the edge back to idle, and `miso_d` changes on the edge away from idle. Both idle levels work.
- R4: Each completed write data byte produces exactly one single-cycle `reg_we`, with `reg_addr` and `reg_wdata` set to that byte's location and value.
- R5: After each data byte the location increments inside its bank. It wraps from 1F to 00 and from 3F to 20.
- R6: In a read, each data byte on `miso_d` is `reg_rdata` for the current location, most significant bit first. A single-cycle `reg_re` with that location follows the last bit of the byte.
- R7: Clock-bank reads of 27, 28..2A, 2B..2F and 33..3F return 00 and raise no `reg_re`. Clock-bank locations 20..26 and 30..32 are readable.
- R8: Writes to 30, 27, 2B..2F and 33..3F raise no `reg_we`. Writes to RAM, 20..26, 28..2A, 31 and 32 do.
- R9: `miso_oe` stays 0 during the command byte and during the whole of a write. In a read it is 1 from the first shift edge of the first data byte.
- R10: Chip enable low drops `miso_oe` and discards any partial byte. A new command then needs chip enable to go low and high again.
- R11: A command byte with bit 6 set makes the rest of the transaction inert: no `reg_we`, no `reg_re` and no MISO drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host |
| miso_d | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad |
| reg_addr | output | 6 | Register-file location |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_re | output | 1 | One-cycle read-complete strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The assertions assume a slow serial clock. Each SCK half period must span several system clocks, enough to cover the synchronizer, the address step and the data load. The assertions also assume MOSI is stable around the sampling edge and SCK rests at its idle level whenever chip enable changes. The stimulus holds each SCK level for eight system clocks and changes MOSI only on the leading edge. It changes the SCK idle level only while chip enable is low, and it waits six clocks on each side of a chip-enable change. Under these conditions no pending address step is cut off by chip enable falling, which the address-increment check relies on.

// File: rtl/spi_reg_access.sv
module spi_reg_access #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_d,
  output logic       miso_oe,
  output logic [5:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {PH_ADDR, PH_WR, PH_RD, PH_SKIP} phase_t;

  logic [LAST:0] ce_sh, sck_sh, mosi_sh;
  logic          ce_s, sck_s, mosi_s, ce_d, sck_d, cpol;
  logic          active, strobe, shift, byte_end;
  phase_t        phase;
  logic [2:0]    bitcnt;
  logic [6:0]    rx;
  logic [7:0]    rx_next, tx, wdata_q;
  logic [5:0]    addr;
  logic          we_q, re_q, adv_q, ld_q, oe_q, miso_q;

  function automatic logic rd_ok(input logic [5:0] a);
    return !a[5] || (a[4:0] <= 5'h06) || (a[4:0] >= 5'h10 && a[4:0] <= 5'h12);
  endfunction

  function automatic logic wr_ok(input logic [5:0] a);
    return !a[5] || (a[4:0] <= 5'h06) || (a[4:0] >= 5'h08 && a[4:0] <= 5'h0A) ||
           (a[4:0] == 5'h11) || (a[4:0] == 5'h12);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sh   <= '0;
      sck_sh  <= '0;
      mosi_sh <= '0;
      ce_d    <= 1'b0;
      sck_d   <= 1'b0;
      cpol    <= 1'b0;
    end else begin
      ce_sh   <= {ce_sh[LAST-1:0], ce_i};
      sck_sh  <= {sck_sh[LAST-1:0], sck_i};
      mosi_sh <= {mosi_sh[LAST-1:0], mosi_i};
      ce_d    <= ce_s;
      sck_d   <= sck_s;
      if (ce_s && !ce_d) cpol <= sck_s;
    end
  end

  assign ce_s     = ce_sh[LAST];
  assign sck_s    = sck_sh[LAST];
  assign mosi_s   = mosi_sh[LAST];
  assign active   = ce_s && ce_d;
  assign strobe   = active && (sck_s != sck_d) && (sck_s == cpol);
  assign shift    = active && (sck_s != sck_d) && (sck_s != cpol);
  assign rx_next  = {rx, mosi_s};
  assign byte_end = strobe && (bitcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_ADDR;
      bitcnt  <= 3'd0;
      rx      <= '0;
      tx      <= '0;
      addr    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      adv_q   <= 1'b0;
      ld_q    <= 1'b0;
      oe_q    <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      re_q  <= 1'b0;
      adv_q <= 1'b0;
      ld_q  <= 1'b0;
      if (!ce_s) begin
        phase  <= PH_ADDR;
        bitcnt <= 3'd0;
        oe_q   <= 1'b0;
      end else begin
        if (strobe) begin
          rx     <= rx_next[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_end) begin
          case (phase)
            PH_ADDR: begin
              if (rx_next[6]) begin
                phase <= PH_SKIP;
              end else begin
                addr  <= rx_next[5:0];
                phase <= rx_next[7] ? PH_WR : PH_RD;
                ld_q  <= !rx_next[7];
              end
            end
            PH_WR: begin
              wdata_q <= rx_next;
              we_q    <= wr_ok(addr);
              adv_q   <= 1'b1;
            end
            PH_RD: begin
              re_q  <= rd_ok(addr);
              adv_q <= 1'b1;
            end
            default: ;
          endcase
        end
        if (adv_q) begin
          addr <= {addr[5], addr[4:0] + 5'd1};
          ld_q <= (phase == PH_RD);
        end
        if (ld_q) tx <= rd_ok(addr) ? reg_rdata : 8'h00;
        if (shift && phase == PH_RD) begin
          miso_q <= tx[7];
          tx     <= {tx[6:0], 1'b0};
          oe_q   <= 1'b1;
        end
      end
    end
  end

  assign miso_d    = miso_q;
  assign miso_oe   = oe_q;
  assign reg_addr  = addr;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_re    = re_q;

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR || phase == PH_ADDR || phase == PH_SKIP) && !oe_q |=> !miso_oe || phase == PH_RD);

  // R10
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !miso_oe && !reg_we && !reg_re);

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  we_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && ce_s |=> reg_addr == {$past(reg_addr[5]), $past(reg_addr[4:0]) + 5'd1});

  // R8
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_addr != 6'h30);

  // R7
  re_readable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> !(reg_addr[5] && reg_addr[4:0] >= 5'h07 && reg_addr[4:0] <= 5'h0F));

  // R11
  skip_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SKIP |-> !reg_we && !reg_re && !miso_oe);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

endmodule

// File: tb/sim_spi_reg_access.sv
module sim_spi_reg_access;
  localparam int PERIOD = 10;
  localparam int HALF   = 8;
  localparam int NVEC   = 13;

  // {cpol, command, data0, data1}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'h85, 8'hA5, 8'h3C},
    {1'b1, 8'h9F, 8'h11, 8'h22},
    {1'b1, 8'h05, 8'h00, 8'h00},
    {1'b0, 8'h1F, 8'h00, 8'h00},
    {1'b1, 8'hBF, 8'h77, 8'h66},
    {1'b0, 8'h3F, 8'h00, 8'h00},
    {1'b0, 8'hA9, 8'h12, 8'h34},
    {1'b1, 8'h29, 8'h00, 8'h00},
    {1'b0, 8'hAF, 8'h55, 8'hAA},
    {1'b1, 8'h30, 8'h00, 8'h00},
    {1'b0, 8'hC5, 8'h99, 8'h98},
    {1'b1, 8'h45, 8'h00, 8'h00},
    {1'b1, 8'h05, 8'h00, 8'h00}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ce_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0;
  logic       miso_d, miso_oe, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  bit   [7:0] mem [64];
  bit   [63:0] wr_mask;
  int         we_tot = 0, re_tot = 0;
  logic [5:0] we_log_a [64];
  logic [7:0] we_log_d [64];
  logic [5:0] re_log_a [64];
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  spi_reg_access u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sck_i(sck_i), .mosi_i(mosi_i),
    .miso_d(miso_d), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  initial forever #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] init_val(input logic [5:0] a);
    return 8'hC3 ^ {2'b00, a};
  endfunction

  assign reg_rdata = wr_mask[reg_addr] ? mem[reg_addr] : init_val(reg_addr);

  always @(negedge clk) begin
    if (reg_we) begin
      mem[reg_addr] = reg_wdata;
      wr_mask[reg_addr] = 1'b1;
      we_log_a[we_tot & 63] = reg_addr;
      we_log_d[we_tot & 63] = reg_wdata;
      we_tot = we_tot + 1;
    end
    if (reg_re) begin
      re_log_a[re_tot & 63] = reg_addr;
      re_tot = re_tot + 1;
    end
  end

  function automatic bit rd_ok_b(input logic [5:0] a);
    return (a <= 6'h1F) || (a >= 6'h20 && a <= 6'h26) || (a >= 6'h30 && a <= 6'h32);
  endfunction

  function automatic bit wr_ok_b(input logic [5:0] a);
    return (a <= 6'h1F) || (a >= 6'h20 && a <= 6'h26) || (a >= 6'h28 && a <= 6'h2A) ||
           a == 6'h31 || a == 6'h32;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spi_bits(input logic cp, input logic [7:0] out, input int n,
                          input logic drive, output logic [7:0] in, output bit bad);
    in = 8'h00;
    bad = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sck_i = ~cp;
      mosi_i = out[i];
      repeat (HALF) @(negedge clk);
      in[i] = miso_d;
      if (miso_oe !== drive) bad = 1'b1;
      sck_i = cp;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic ce_up(input logic cp);
    sck_i = cp;
    mosi_i = 1'b0;
    repeat (6) @(negedge clk);
    ce_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ce_down;
    repeat (6) @(negedge clk);
    ce_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic txn(input logic cp, input logic [7:0] cmd, input logic [7:0] d0,
                     input logic [7:0] d1, output logic [7:0] r0, output logic [7:0] r1,
                     output bit bad);
    logic [7:0] dummy;
    bit b0, b1, b2;
    logic rd;
    rd = !cmd[7] && !cmd[6];
    ce_up(cp);
    spi_bits(cp, cmd, 8, 1'b0, dummy, b0);
    spi_bits(cp, d0, 8, rd, r0, b1);
    spi_bits(cp, d1, 8, rd, r1, b2);
    ce_down();
    bad = b0 | b1 | b2;
  endtask

  initial begin
    logic [7:0] exp_mem [64];
    logic [7:0] g0, g1, tmp;
    bit bad;
    int we0, re0;
    for (int a = 0; a < 64; a++) exp_mem[a] = init_val(6'(a));

    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {31'd0, miso_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe after reset", {31'd0, miso_oe}, 0);
    chk("R1 we after reset", {31'd0, reg_we}, 0);
    chk("R1 re after reset", {31'd0, reg_re}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic cp;
      logic [7:0] cmd, d0, d1;
      logic [5:0] a0, a1;
      logic [5:0] ea [2];
      logic [7:0] ed [2];
      int n;
      cp = VEC[v][24]; cmd = VEC[v][23:16]; d0 = VEC[v][15:8]; d1 = VEC[v][7:0];
      a0 = cmd[5:0];
      a1 = {a0[5], a0[4:0] + 5'd1};
      we0 = we_tot; re0 = re_tot;
      txn(cp, cmd, d0, d1, g0, g1, bad);
      chk($sformatf("R9 vec%0d cpol%0d MISO enable window", v, cp), {31'd0, bad}, 0);
      n = 0;
      if (cmd[6]) begin
        chk($sformatf("R11 vec%0d writes", v), we_tot - we0, 0);
        chk($sformatf("R11 vec%0d read strobes", v), re_tot - re0, 0);
      end else if (cmd[7]) begin
        if (wr_ok_b(a0)) begin ea[n] = a0; ed[n] = d0; n++; exp_mem[a0] = d0; end
        if (wr_ok_b(a1)) begin ea[n] = a1; ed[n] = d1; n++; exp_mem[a1] = d1; end
        chk($sformatf("R4/R8 vec%0d write count", v), we_tot - we0, n);
        for (int i = 0; i < n; i++) begin
          chk($sformatf("R5 vec%0d write addr %0d", v, i), {26'd0, we_log_a[(we0 + i) & 63]}, {26'd0, ea[i]});
          chk($sformatf("R4 vec%0d write data %0d", v, i), {24'd0, we_log_d[(we0 + i) & 63]}, {24'd0, ed[i]});
        end
        chk($sformatf("R4 vec%0d no read strobe", v), re_tot - re0, 0);
      end else begin
        chk($sformatf("R6/R7 R3 vec%0d cpol%0d byte0", v, cp), {24'd0, g0},
            {24'd0, rd_ok_b(a0) ? exp_mem[a0] : 8'h00});
        chk($sformatf("R5/R7 vec%0d byte1", v), {24'd0, g1},
            {24'd0, rd_ok_b(a1) ? exp_mem[a1] : 8'h00});
        if (rd_ok_b(a0)) begin ea[n] = a0; n++; end
        if (rd_ok_b(a1)) begin ea[n] = a1; n++; end
        chk($sformatf("R6/R7 vec%0d read strobe count", v), re_tot - re0, n);
        for (int i = 0; i < n; i++)
          chk($sformatf("R6 vec%0d read strobe addr %0d", v, i), {26'd0, re_log_a[(re0 + i) & 63]}, {26'd0, ea[i]});
        chk($sformatf("R2 vec%0d no write in read", v), we_tot - we0, 0);
      end
    end

    // R10: partial command byte is dropped, next transaction starts fresh
    we0 = we_tot;
    ce_up(1'b0);
    spi_bits(1'b0, 8'h86, 4, 1'b0, tmp, bad);
    ce_down();
    chk("R10 partial byte no write", we_tot - we0, 0);
    txn(1'b0, 8'h86, 8'h5E, 8'h71, g0, g1, bad);
    chk("R10 fresh write count", we_tot - we0, 2);
    chk("R10 fresh write addr", {26'd0, we_log_a[we0 & 63]}, 32'h06);
    chk("R2 fresh write data", {24'd0, we_log_d[we0 & 63]}, 32'h5E);

    // R10: chip enable dropped inside a read data byte
    re0 = re_tot;
    ce_up(1'b1);
    spi_bits(1'b1, 8'h06, 8, 1'b0, tmp, bad);
    spi_bits(1'b1, 8'h00, 8, 1'b1, g0, bad);
    chk("R6 read before abort", {24'd0, g0}, 32'h5E);
    spi_bits(1'b1, 8'h00, 3, 1'b1, g1, bad);
    chk("R9 driving mid byte", {31'd0, miso_oe}, 1);
    ce_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 oe released", {31'd0, miso_oe}, 0);
    chk("R10 partial read no strobe", re_tot - re0, 1);
    repeat (6) @(negedge clk);
    txn(1'b1, 8'h07, 8'h00, 8'h00, g0, g1, bad);
    chk("R10 new command read", {24'd0, g0}, 32'h71);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule